// File: doc/BRIEF.md
# Interrupt Priority Chain Controller

This block arbitrates six interrupt sources inside a two-channel serial controller and joins them to an external priority chain. Each channel has three sources: receive, transmit and external/status. The block raises an active-low interrupt request. It answers the processor's acknowledge cycle with an 8-bit vector, and it tracks which source is being serviced through one in-service latch per source.

The chain input says whether any device of higher priority is being serviced. The chain output passes that permission on to devices of lower priority. The block watches opcode fetches on the data bus so that it can recognise the two-byte return-from-interrupt sequence. On the first byte it opens the chain past its own pending requests. On the second byte only the device holding the chain clears its most urgent in-service latch. The three low-middle vector bits can optionally be replaced by a code for the source.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While `rst_n` is low, all pending and in-service state and the return-sequence state are cleared. In this state `int_n` is high, `vec_oe` is low and `ieo` equals `iei`.
- R2: The source index gives the fixed priority. Index 0 is channel A receive, 1 is A transmit, 2 is A external/status, 3 is B receive, 4 is B transmit and 5 is B external/status. Index 0 is the most urgent.
- R3: `int_n` is low exactly when `iei` is high and some pending source has no in-service latch set at its own or a more urgent index.
- R4: Outside a return sequence, `ieo` is `iei` with every pending or in-service source cleared. Any such source forces `ieo` low.
- R5: A source is pending when its `req` bit and `src_en` bit are both high. The pending set is sampled on a clock edge only while `m1_n` is high, and it is held while `m1_n` is low.
- R6: An acknowledge is `m1_n` and `iorq_n` both low. If `iei` is high and R3's condition holds, `vec_oe` is high for the whole acknowledge. The eligible source chosen at the first acknowledge cycle gets its in-service latch set on that edge, and it stays the vector's source until the acknowledge ends. Otherwise `vec_oe` stays low and no latch changes.
- R7: With `vec_mod` low, `vec_out` equals `vec_base`. With `vec_mod` high, bits 3..1 carry the chosen source index as a 3-bit number, and the other bits come from `vec_base`.
- R8: An opcode fetch is `m1_n` and `rd_n` both low, and its byte is taken from `data_in` in the first fetch cycle. A fetched 8'hED enters the return state. In that state pending requests no longer pull `ieo` low, and only in-service latches do.
- R9: A fetched 8'h4D in the return state, with `iei` high and some latch in service, clears only the most urgent in-service latch. One sequence therefore unwinds one nesting level.
- R10: Any fetched byte other than 8'hED ends the return state. If that byte is not 8'h4D, or `iei` is low, the in-service latches are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 6 | Source request levels, index per R2 |
| src_en | input | 6 | Per-source interrupt enables |
| vec_base | input | 8 | Programmed interrupt vector |
| vec_mod | input | 1 | Replace vector bits 3..1 with source code |
| iei | input | 1 | Chain enable in, high = permitted |
| m1_n | input | 1 | Machine-cycle strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_in | input | 8 | Data bus as seen by the block |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable out |
| vec_out | output | 8 | Vector to drive onto the bus |
| vec_oe | output | 1 | Vector drive enable |

## Verification
Two events can coincide in one edge. One is a new request edge that arrives while `m1_n` is low. The other is the return byte that clears an in-service latch. The bench raises a more urgent request in the same cycle as the 8'h4D fetch. The clear must take effect at that edge, and the new request must stay invisible to `int_n` and `ieo` until `m1_n` rises. Nested acknowledges are also interleaved with return sequences under random request, enable and chain-input patterns. A behavioural model is compared against the outputs in every cycle.

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
  parameter int NSRC = 6,
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] src_en,
  input  logic [VW-1:0]   vec_base,
  input  logic            vec_mod,
  input  logic            iei,
  input  logic            m1_n,
  input  logic            iorq_n,
  input  logic            rd_n,
  input  logic [7:0]      data_in,
  output logic            int_n,
  output logic            ieo,
  output logic [VW-1:0]   vec_out,
  output logic            vec_oe
);
  localparam int IW = 3;
  localparam logic [7:0] OP_PRE = 8'hED;
  localparam logic [7:0] OP_RET = 8'h4D;

  logic [NSRC-1:0] pend, insvc, insvc_nx;
  logic            ret_q, ack_q, fetch_q, hit_q;
  logic [IW-1:0]   idx_q;

  logic ack, fetch, ack_start, fetch_start;
  assign ack         = ~m1_n & ~iorq_n;
  assign fetch       = ~m1_n & ~rd_n;
  assign ack_start   = ack & ~ack_q;
  assign fetch_start = fetch & ~fetch_q;

  logic          win_hit, blocked;
  logic [IW-1:0] win_idx;
  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    blocked = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      blocked = blocked | insvc[i];
      if (!win_hit && pend[i] && !blocked) begin
        win_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  logic          clr_hit;
  logic [IW-1:0] clr_idx;
  always_comb begin
    clr_hit = 1'b0;
    clr_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (!clr_hit && insvc[i]) begin
        clr_hit = 1'b1;
        clr_idx = IW'(i);
      end
  end

  logic          sel_hit;
  logic [IW-1:0] sel_idx;
  assign sel_hit = ack_q ? hit_q : (win_hit & iei);
  assign sel_idx = ack_q ? idx_q : win_idx;

  assign int_n  = ~(iei & win_hit);
  assign ieo    = iei & ~(|insvc) & (ret_q | ~(|pend));
  assign vec_oe = ack & iei & sel_hit;
  assign vec_out = vec_mod ? {vec_base[VW-1:4], sel_idx, vec_base[0]} : vec_base;

  logic do_ret;
  assign do_ret = fetch_start & ret_q & (data_in == OP_RET) & iei & clr_hit;

  always_comb begin
    insvc_nx = insvc;
    if (ack_start && iei && win_hit) insvc_nx[win_idx] = 1'b1;
    if (do_ret) insvc_nx[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      insvc   <= '0;
      ret_q   <= 1'b0;
      ack_q   <= 1'b0;
      fetch_q <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (m1_n) pend <= req & src_en;
      insvc   <= insvc_nx;
      ack_q   <= ack;
      fetch_q <= fetch;
      if (ack_start) begin
        hit_q <= win_hit & iei;
        idx_q <= win_idx;
      end
      if (fetch_start) ret_q <= (data_in == OP_PRE);
    end
  end

  a_r5_pend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && $past(!m1_n)) |-> $stable(pend));

  a_r3_int_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> iei);

  a_r6_ack_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && iei && !int_n && !fetch_start) |=>
      ($countones(insvc) == $past($countones(insvc)) + 1));

  a_r9_ret_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && !ack_start) |=>
      ($countones(insvc) + 1 == $past($countones(insvc))));

  a_r6_vec_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (!m1_n && !iorq_n && iei));

  a_r8_open_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q && iei && insvc == '0) |-> ieo);
endmodule

// File: tb/irq_chain_ctrl_test.sv
module irq_chain_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] req = 0, src_en = 0;
  logic [7:0] vec_base = 8'hA1;
  logic       vec_mod = 0, iei = 1, m1_n = 1, iorq_n = 1, rd_n = 1;
  logic [7:0] data_in = 0;
  logic       int_n, ieo, vec_oe;
  logic [7:0] vec_out;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  irq_chain_ctrl uut (.clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en),
    .vec_base(vec_base), .vec_mod(vec_mod), .iei(iei), .m1_n(m1_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .data_in(data_in), .int_n(int_n),
    .ieo(ieo), .vec_out(vec_out), .vec_oe(vec_oe));

  bit mp[6], ms[6];
  bit med, mack_prev, mfetch_prev, mhit;
  int midx;

  function automatic int winner();
    for (int i = 0; i < 6; i++) begin
      if (ms[i]) return -1;
      if (mp[i]) return i;
    end
    return -1;
  endfunction

  function automatic bit any_s();
    for (int i = 0; i < 6; i++) if (ms[i]) return 1;
    return 0;
  endfunction

  function automatic bit any_p();
    for (int i = 0; i < 6; i++) if (mp[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit ack, fetch;
    int w;
    ack   = !m1_n && !iorq_n;
    fetch = !m1_n && !rd_n;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin mp[i] = 0; ms[i] = 0; end
      med = 0; mack_prev = 0; mfetch_prev = 0; mhit = 0; midx = 0;
    end else begin
      w = winner();
      if (ack && !mack_prev) begin
        mhit = iei && (w >= 0);
        midx = (w >= 0) ? w : 0;
        if (mhit) ms[w] = 1;
      end
      if (fetch && !mfetch_prev) begin
        if (data_in == 8'hED) med = 1;
        else begin
          if (med && data_in == 8'h4D && iei) begin
            for (int i = 0; i < 6; i++)
              if (ms[i]) begin ms[i] = 0; break; end
          end
          med = 0;
        end
      end
      if (m1_n) for (int i = 0; i < 6; i++) mp[i] = req[i] & src_en[i];
      mack_prev = ack;
      mfetch_prev = fetch;
    end
  end

  task automatic check1(string r, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h at %0t", r, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    int w;
    bit e_int, e_ieo, e_oe, hit;
    int idx;
    logic [7:0] e_vec;
    w = winner();
    e_int = !(iei && w >= 0);
    e_ieo = iei && !any_s() && (med || !any_p());
    hit = mack_prev ? mhit : (iei && w >= 0);
    idx = mack_prev ? midx : ((w >= 0) ? w : 0);
    e_oe = !m1_n && !iorq_n && iei && hit;
    e_vec = vec_mod ? {vec_base[7:4], 3'(idx), vec_base[0]} : vec_base;
    check1((tag == "") ? "R3" : tag, "int_n", int_n, e_int);
    check1((tag == "") ? "R4" : tag, "ieo", ieo, e_ieo);
    check1((tag == "") ? "R6" : tag, "vec_oe", vec_oe, e_oe);
    if (e_oe) check1((tag == "") ? "R7" : tag, "vec_out", vec_out, e_vec);
  endtask

  task automatic cyc(input bit m1, input bit iorq, input bit rd, input logic [7:0] d);
    @(negedge clk);
    compare();
    m1_n = m1; iorq_n = iorq; rd_n = rd; data_in = d;
    #1 compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 8'h00);
  endtask

  task automatic acknowledge();
    cyc(0, 1, 1, 8'h00);
    cyc(0, 0, 1, 8'h00);
    cyc(0, 0, 1, 8'h00);
    cyc(1, 1, 1, 8'h00);
  endtask

  task automatic fetch_byte(logic [7:0] b);
    cyc(0, 1, 0, b);
    cyc(0, 1, 0, b);
    cyc(1, 1, 1, 8'h00);
  endtask

  initial begin
    fork
      begin
        tag = "R1";
        src_en = 6'h3F; req = 6'h3F; iei = 1;
        repeat (3) @(negedge clk);
        check1("R1", "int_n in reset", int_n, 1);
        check1("R1", "vec_oe in reset", vec_oe, 0);
        check1("R1", "ieo in reset", ieo, iei);
        @(negedge clk) rst_n = 1; req = 0;
        idle(3);

        tag = "R2";
        req = 6'b101100; idle(2);
        vec_mod = 1; acknowledge();
        req = 6'b101000; idle(2);
        tag = "R9"; fetch_byte(8'hED); fetch_byte(8'h4D); idle(2);
        tag = "R3"; idle(2);

        tag = "R9";
        req = 6'b100000; idle(2);
        acknowledge();
        req = 6'b100010; idle(2);
        acknowledge();
        fetch_byte(8'hED);
        tag = "R8"; idle(2);
        tag = "R9"; fetch_byte(8'h4D); idle(2);
        req = 0; idle(1);
        fetch_byte(8'hED); fetch_byte(8'h4D); idle(2);

        tag = "R10";
        req = 6'b000001; idle(2); acknowledge(); req = 0; idle(1);
        fetch_byte(8'hED); fetch_byte(8'h00); fetch_byte(8'h4D); idle(2);
        iei = 0; fetch_byte(8'hED); fetch_byte(8'h4D); idle(1);
        iei = 1; idle(1);
        fetch_byte(8'hED); fetch_byte(8'hED); fetch_byte(8'h4D); idle(2);

        tag = "R5";
        cyc(0, 1, 0, 8'hED); cyc(0, 1, 0, 8'hED); cyc(1, 1, 1, 8'h00);
        req = 6'b000100; idle(2); acknowledge(); req = 6'b000000; idle(1);
        fetch_byte(8'hED);
        cyc(0, 1, 0, 8'h4D);
        req = 6'b000001;
        cyc(0, 1, 0, 8'h4D);
        cyc(0, 1, 1, 8'h00);
        cyc(1, 1, 1, 8'h00); idle(2);
        acknowledge(); req = 0; fetch_byte(8'hED); fetch_byte(8'h4D); idle(2);

        tag = "R11";
        src_en = 6'b111110; req = 6'b000001; idle(3);
        tag = "R6"; iei = 0; req = 6'b000010; idle(2); acknowledge();
        iei = 1; idle(1);
        vec_mod = 0; vec_base = 8'h5E; acknowledge(); req = 0;
        fetch_byte(8'hED); fetch_byte(8'h4D); idle(2);

        tag = "";
        src_en = 6'h3F;
        for (int k = 0; k < 400; k++) begin
          int op;
          op = $urandom_range(0, 5);
          if ($urandom_range(0, 3) == 0) req = 6'($urandom);
          if ($urandom_range(0, 7) == 0) src_en = 6'($urandom);
          if ($urandom_range(0, 9) == 0) iei = ~iei;
          vec_mod = 1'($urandom);
          vec_base = 8'($urandom);
          case (op)
            0, 1: idle(1);
            2: acknowledge();
            3: fetch_byte(8'hED);
            4: fetch_byte(8'h4D);
            default: fetch_byte(8'($urandom));
          endcase
        end
        idle(2);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule